// File: doc/BRIEF.md
# Dual-Channel Phase Detector with Lock Qualification

This block compares, for each of two synthesizer channels, a reference pulse train with a divided feedback pulse train. Both trains are sampled on the system clock, which is also the reference oscillator clock. The block turns the timing difference between their rising edges into a three-state correction command: drive high, drive low, or release (high impedance). The command is carried on two wires per channel. `cp_oe` enables the driver and `cp_hi` gives its level. A charge pump outside the block turns this command into current.

Every completed comparison also yields a phase error: the number of clock cycles from the leading edge to the lagging edge. A lock qualifier takes lock away on the first large error, and grants it again only after a run of small errors. The per-channel results are merged into one lock flag. A channel in power save releases its output and counts as locked in that flag. On leaving power save, the first comparison is thrown away so that a stale phase relation cannot produce a large correction step.

Top module: `pd_dual_detector`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cp_oe`, `cp_hi`, `ch_locked` and `lock_all` are all 0.
- R2: With `pol` = 1, a channel whose reference edge comes first drives high (`cp_hi` = 1) and one whose feedback edge comes first drives low (`cp_hi` = 0) for the whole correction pulse.
- R3: With `pol` = 0, the levels of R2 are swapped: a leading reference drives low and a leading feedback drives high.
- R4: Reference and feedback rising edges that arrive in the same clock cycle give a phase error of 0 and leave the output released (`cp_oe` = 0).
- R5: The phase error is the count of clock cycles between the two rising edges. A nonzero error E gives one correction pulse of max(E, MIN_PULSE) cycles (MIN_PULSE = 2), so that even a one-cycle error produces a two-cycle pulse.
- R6: Further rising edges of the leading train, seen before the lagging edge arrives, are ignored. The error is measured from the first leading edge.
- R7: A comparison whose error is at or above UNLOCK_TH (3 cycles) clears `ch_locked` at once.
- R8: `ch_locked` rises only after LOCK_RUN (3) consecutive comparisons, each with an error at or below LOCK_TH (2 cycles). A large error restarts the run.
- R9: While `pwr_save` is 1 for a channel, its output is released, its edges produce no pulse, and its `ch_locked` reads 0.
- R10: After `pwr_save` returns to 0, the channel's first comparison produces no pulse and does not count toward the lock run. The comparisons after it behave normally.
- R11: `lock_all` is 1 exactly when every channel is locked or in power save. It follows one cycle after the per-channel state.
- R12: `cp_hi` is 0 in every cycle in which `cp_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | NCH | Reference pulse train per channel |
| fb_in | input | NCH | Feedback pulse train per channel |
| pol | input | NCH | Output polarity per channel (1: reference leading drives high) |
| pwr_save | input | NCH | Power save per channel |
| cp_oe | output | NCH | Correction driver enable (0 = high impedance) |
| cp_hi | output | NCH | Correction driver level while enabled |
| ch_locked | output | NCH | Per-channel lock status |
| lock_all | output | 1 | Merged lock: every channel locked or in power save |

## Verification
A sweep over both polarities runs single comparisons with signed edge offsets from -5 to +5 cycles. Pulse width and level are counted at the ports. This separates the minimum-width extension (offsets of ±1) from plain error tracking (offsets of 2 and above), the aligned case from both leading cases, and one polarity from the other. Scripted error sequences then set runs of small errors against single large ones, which shows that lock is granted only after a full run and is lost at once. A repeated leading edge checks that the error is measured from the first edge. Power-save entry and exit on each channel shows the released output, the masked first comparison, and the merged flag treating saved channels as locked.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_REF_AHEAD = 2'd1,
    PH_FB_AHEAD  = 2'd2
  } ph_state_e;
endpackage

// File: rtl/pd_edge.sv
module pd_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/pd_phase_meter.sv
module pd_phase_meter
  import pd_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int MIN_PULSE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic             fb_rise,
  input  logic             pol,
  input  logic             pwr_save,
  output logic             cp_oe,
  output logic             cp_hi,
  output logic             evt_valid,
  output logic             evt_flush,
  output logic [CNT_W-1:0] evt_err,
  output logic             ps_q
);
  localparam int              EXT_W   = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MINP    = CNT_W'(MIN_PULSE);
  localparam logic [EXT_W-1:0] EXT_LEN = EXT_W'(MIN_PULSE);

  ph_state_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n, err;
  logic [EXT_W-1:0] ext, ext_n;
  logic             ext_dir, ext_dir_n;
  logic             mask, mask_n;
  logic             evt, ref_won;
  logic             drive_n, ref_ahead_n, hi_n;

  // phase measurement state machine
  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    evt     = 1'b0;
    err     = '0;
    ref_won = 1'b0;
    unique case (st)
      PH_IDLE: begin
        if (ref_rise && fb_rise) begin
          evt = 1'b1;
        end else if (ref_rise) begin
          st_n  = PH_REF_AHEAD;
          cnt_n = CNT_W'(1);
        end else if (fb_rise) begin
          st_n  = PH_FB_AHEAD;
          cnt_n = CNT_W'(1);
        end
      end
      PH_REF_AHEAD: begin
        if (fb_rise) begin
          evt     = 1'b1;
          err     = cnt;
          ref_won = 1'b1;
          st_n    = PH_IDLE;
          cnt_n   = '0;
        end else if (cnt != CNT_MAX) begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      PH_FB_AHEAD: begin
        if (ref_rise) begin
          evt   = 1'b1;
          err   = cnt;
          st_n  = PH_IDLE;
          cnt_n = '0;
        end else if (cnt != CNT_MAX) begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      default: begin
        st_n  = PH_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  // minimum-width extension, masking and output level
  always_comb begin
    ext_n     = ext;
    ext_dir_n = ext_dir;
    if (st_n != PH_IDLE) begin
      ext_n = '0;
    end else if (evt && !mask && (err != '0) && (err < MINP)) begin
      ext_n     = EXT_LEN - EXT_W'(err);
      ext_dir_n = ref_won;
    end else if (ext != '0) begin
      ext_n = ext - EXT_W'(1);
    end
    mask_n      = evt ? 1'b0 : mask;
    drive_n     = !mask && ((st_n != PH_IDLE) || (ext_n != '0));
    ref_ahead_n = (st_n == PH_REF_AHEAD) || ((st_n == PH_IDLE) && ext_dir_n);
    hi_n        = drive_n && (pol ? ref_ahead_n : !ref_ahead_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      ext       <= '0;
      ext_dir   <= 1'b0;
      mask      <= 1'b0;
      cp_oe     <= 1'b0;
      cp_hi     <= 1'b0;
      evt_valid <= 1'b0;
      evt_flush <= 1'b0;
      evt_err   <= '0;
      ps_q      <= 1'b0;
    end else if (pwr_save) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      ext       <= '0;
      ext_dir   <= 1'b0;
      mask      <= 1'b1;
      cp_oe     <= 1'b0;
      cp_hi     <= 1'b0;
      evt_valid <= 1'b0;
      evt_flush <= 1'b1;
      evt_err   <= '0;
      ps_q      <= 1'b1;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      ext       <= ext_n;
      ext_dir   <= ext_dir_n;
      mask      <= mask_n;
      cp_oe     <= drive_n;
      cp_hi     <= hi_n;
      evt_valid <= evt && !mask;
      evt_flush <= evt && mask;
      evt_err   <= err;
      ps_q      <= 1'b0;
    end
  end
endmodule

// File: rtl/pd_lock_judge.sv
module pd_lock_judge #(
  parameter int CNT_W     = 6,
  parameter int UNLOCK_TH = 3,
  parameter int LOCK_TH   = 2,
  parameter int LOCK_RUN  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic             evt_flush,
  input  logic [CNT_W-1:0] evt_err,
  output logic             locked
);
  localparam int               RUN_W    = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(LOCK_RUN);
  localparam logic [CNT_W-1:0] BIG_ERR  = CNT_W'(UNLOCK_TH);
  localparam logic [CNT_W-1:0] FINE_ERR = CNT_W'(LOCK_TH);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || evt_flush) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (evt_valid) begin
      if (evt_err >= BIG_ERR) begin
        run    <= '0;
        locked <= 1'b0;
      end else if (evt_err <= FINE_ERR) begin
        if (run >= RUN_LAST) locked <= 1'b1;
        if (run != RUN_TOP)  run    <= run + RUN_W'(1);
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/pd_lock_merge.sv
module pd_lock_merge #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_locked,
  input  logic [NCH-1:0] ch_saved,
  output logic           lock_all
);
  always_ff @(posedge clk) begin
    if (rst) lock_all <= 1'b0;
    else     lock_all <= &(ch_locked | ch_saved);
  end
endmodule

// File: rtl/pd_dual_detector.sv
module pd_dual_detector #(
  parameter int NCH       = 2,
  parameter int CNT_W     = 6,
  parameter int MIN_PULSE = 2,
  parameter int UNLOCK_TH = 3,
  parameter int LOCK_TH   = 2,
  parameter int LOCK_RUN  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ref_in,
  input  logic [NCH-1:0] fb_in,
  input  logic [NCH-1:0] pol,
  input  logic [NCH-1:0] pwr_save,
  output logic [NCH-1:0] cp_oe,
  output logic [NCH-1:0] cp_hi,
  output logic [NCH-1:0] ch_locked,
  output logic           lock_all
);
  logic [NCH-1:0]       ref_rise, fb_rise;
  logic [NCH-1:0]       evt_v, evt_f, save_q;
  logic [NCH*CNT_W-1:0] evt_e;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pd_edge u_ref_edge (.clk(clk), .rst(rst), .sig(ref_in[c]), .rise(ref_rise[c]));
    pd_edge u_fb_edge  (.clk(clk), .rst(rst), .sig(fb_in[c]),  .rise(fb_rise[c]));

    pd_phase_meter #(.CNT_W(CNT_W), .MIN_PULSE(MIN_PULSE)) u_meter (
      .clk(clk), .rst(rst),
      .ref_rise(ref_rise[c]), .fb_rise(fb_rise[c]),
      .pol(pol[c]), .pwr_save(pwr_save[c]),
      .cp_oe(cp_oe[c]), .cp_hi(cp_hi[c]),
      .evt_valid(evt_v[c]), .evt_flush(evt_f[c]),
      .evt_err(evt_e[c*CNT_W +: CNT_W]),
      .ps_q(save_q[c])
    );

    pd_lock_judge #(.CNT_W(CNT_W), .UNLOCK_TH(UNLOCK_TH), .LOCK_TH(LOCK_TH),
                    .LOCK_RUN(LOCK_RUN)) u_judge (
      .clk(clk), .rst(rst),
      .evt_valid(evt_v[c]), .evt_flush(evt_f[c]),
      .evt_err(evt_e[c*CNT_W +: CNT_W]),
      .locked(ch_locked[c])
    );
  end

  pd_lock_merge #(.NCH(NCH)) u_merge (
    .clk(clk), .rst(rst),
    .ch_locked(ch_locked), .ch_saved(save_q),
    .lock_all(lock_all)
  );
endmodule

// File: rtl/pd_dual_detector_chk.sv
module pd_dual_detector_chk #(
  parameter int NCH       = 2,
  parameter int CNT_W     = 6,
  parameter int UNLOCK_TH = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH-1:0]       cp_oe,
  input logic [NCH-1:0]       ch_locked,
  input logic                 lock_all,
  input logic [NCH-1:0]       ps_q,
  input logic [NCH-1:0]       evt_valid,
  input logic [NCH*CNT_W-1:0] evt_err
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_saved_released_r9: assert property (@(posedge clk) disable iff (rst)
      ps_q[c] |-> !cp_oe[c]);

    p_min_width_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(cp_oe[c]) |=> (cp_oe[c] || ps_q[c]));

    p_big_error_unlocks_r7: assert property (@(posedge clk) disable iff (rst)
      (evt_valid[c] && (evt_err[c*CNT_W +: CNT_W] >= CNT_W'(UNLOCK_TH)))
        |=> !ch_locked[c]);

    p_lock_after_compare_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_locked[c]) |-> $past(evt_valid[c]));

    p_merge_blocks_r11: assert property (@(posedge clk) disable iff (rst)
      (!ch_locked[c] && !ps_q[c]) |=> !lock_all);
  end
endmodule

bind pd_dual_detector pd_dual_detector_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .UNLOCK_TH(UNLOCK_TH)
) u_chk (
  .clk(clk), .rst(rst), .cp_oe(cp_oe), .ch_locked(ch_locked),
  .lock_all(lock_all), .ps_q(save_q), .evt_valid(evt_v), .evt_err(evt_e)
);

// File: tb/tb_pd_dual_detector.sv
`timescale 1ns/1ps
module tb_pd_dual_detector;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] ref_in = '0, fb_in = '0, pol = '0, pwr_save = '0;
  logic [NCH-1:0] cp_oe, cp_hi, ch_locked;
  logic           lock_all;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  int good_m [NCH];
  bit lock_m [NCH];
  bit mask_m [NCH];

  always #10 clk = ~clk;

  pd_dual_detector dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .pol(pol),
    .pwr_save(pwr_save), .cp_oe(cp_oe), .cp_hi(cp_hi),
    .ch_locked(ch_locked), .lock_all(lock_all)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // drives one comparison window and counts what the outputs do
  task automatic run_cmp(input int ch, input int t_ref, input int t_fb, input int t_ref2,
                         output int act, output int hic, output int zbad);
    act = 0; hic = 0; zbad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (cp_oe[ch]) begin
        act++;
        if (cp_hi[ch]) hic++;
      end else if (cp_hi[ch]) begin
        zbad++;
      end
      ref_in[ch] = (i == t_ref) || (i == t_ref2);
      fb_in[ch]  = (i == t_fb);
    end
    @(negedge clk);
    ref_in[ch] = 1'b0;
    fb_in[ch]  = 1'b0;
  endtask

  function automatic void model_cmp(input int ch, input int err);
    if (mask_m[ch]) begin
      mask_m[ch] = 1'b0;
      good_m[ch] = 0;
    end else if (err >= 3) begin
      lock_m[ch] = 1'b0;
      good_m[ch] = 0;
    end else begin
      if (good_m[ch] < 3) good_m[ch]++;
      if (good_m[ch] >= 3) lock_m[ch] = 1'b1;
    end
  endfunction

  // d > 0: reference leads by d cycles; d < 0: feedback leads
  task automatic cmp_check(input int ch, input int d);
    int act, hic, zbad, e, exp_act, exp_hi;
    bit ref_lead;
    e        = (d < 0) ? -d : d;
    ref_lead = (d > 0);
    exp_act  = (mask_m[ch] || e == 0) ? 0 : ((e < 2) ? 2 : e);
    exp_hi   = (exp_act != 0 && (ref_lead == pol[ch])) ? exp_act : 0;
    run_cmp(ch, 5, 5 + d, -1, act, hic, zbad);
    if (e == 0) check("R4", act, 0, $sformatf("aligned drive cycles ch%0d", ch));
    else if (mask_m[ch]) check("R10", act, 0, $sformatf("masked drive cycles ch%0d d=%0d", ch, d));
    else check("R5", act, exp_act, $sformatf("pulse width ch%0d d=%0d", ch, d));
    if (pol[ch]) check("R2", hic, exp_hi, $sformatf("high cycles pol1 ch%0d d=%0d", ch, d));
    else         check("R3", hic, exp_hi, $sformatf("high cycles pol0 ch%0d d=%0d", ch, d));
    check("R12", zbad, 0, $sformatf("level while released ch%0d d=%0d", ch, d));
    model_cmp(ch, e);
  endtask

  task automatic check_lock(input string req);
    bit exp_all;
    @(negedge clk);
    @(negedge clk);
    exp_all = 1'b1;
    for (int c = 0; c < NCH; c++) exp_all &= (lock_m[c] | pwr_save[c]);
    check(req, ch_locked[0], lock_m[0], "ch0 lock");
    check(req, ch_locked[1], lock_m[1], "ch1 lock");
    check("R11", lock_all, exp_all, "merged lock");
  endtask

  task automatic set_ps(input int ch, input bit v);
    @(negedge clk);
    pwr_save[ch] = v;
    if (v) begin
      lock_m[ch] = 1'b0;
      good_m[ch] = 0;
      mask_m[ch] = 1'b1;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int act, hic, zbad;
    for (int c = 0; c < NCH; c++) begin
      good_m[c] = 0; lock_m[c] = 1'b0; mask_m[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    check("R1", cp_oe, 0, "oe in reset");
    check("R1", ch_locked, 0, "lock in reset");
    check("R1", lock_all, 0, "merged lock in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", cp_hi, 0, "level after reset");
    set_ps(1, 1'b1);

    // polarity and offset sweep on channel 0
    for (int p = 0; p < 2; p++) begin
      pol[0] = p[0];
      for (int d = -5; d <= 5; d++) cmp_check(0, d);
    end

    // lock qualification, polarity 1
    pol[0] = 1'b1;
    check_lock("R8");
    cmp_check(0, 1);
    cmp_check(0, -1);
    check_lock("R8");
    cmp_check(0, 2);
    check_lock("R8");
    cmp_check(0, -2);
    check_lock("R8");
    cmp_check(0, 3);
    check_lock("R7");
    cmp_check(0, 0);
    cmp_check(0, 0);
    cmp_check(0, 4);
    cmp_check(0, 0);
    check_lock("R8");
    cmp_check(0, 0);
    cmp_check(0, 0);
    check_lock("R8");

    // repeated leading edge: measured from the first one
    run_cmp(0, 5, 10, 8, act, hic, zbad);
    check("R6", act, 5, "width with second reference edge");
    check("R6", hic, 5, "high cycles with second reference edge");
    model_cmp(0, 5);
    check_lock("R7");
    for (int k = 0; k < 3; k++) cmp_check(0, 1);
    check_lock("R8");

    // merge and power save on channel 0
    cmp_check(0, 3);
    check_lock("R11");
    set_ps(0, 1'b1);
    check_lock("R9");
    run_cmp(0, 5, 8, -1, act, hic, zbad);
    check("R9", act, 0, "drive cycles in power save");
    check_lock("R9");
    set_ps(0, 1'b0);
    cmp_check(0, 0);
    cmp_check(0, 0);
    cmp_check(0, 0);
    check_lock("R10");
    cmp_check(0, 0);
    check_lock("R10");
    cmp_check(0, 4);

    // channel 1 leaves power save: merged flag must depend on it
    for (int k = 0; k < 3; k++) cmp_check(0, 0);
    check_lock("R11");
    set_ps(1, 1'b0);
    check_lock("R11");
    pol[1] = 1'b0;
    cmp_check(1, 2);
    for (int k = 0; k < 3; k++) cmp_check(1, -1);
    check_lock("R11");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule